// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block returns a wedged two-wire bus to a known idle state before the byte-transfer engine resumes. A slave left mid-byte can hold the data line low indefinitely, and no normal transfer can begin while it does. On a kick, the sequencer first asks the controller to clear its sticky completion, interrupt and error flags. It then waits a bounded time for any transfer still in flight to drain, and places the controller in soft reset. While in soft reset it takes over both lines.

With both lines released, the sequencer samples them. While either line reads low, it toggles the clock line once and samples again, up to a fixed number of pulses. It then writes a start condition and a stop condition onto the bus, releases soft reset, waits a settle interval and pulses a done output. If the bus is still not free after the last permitted pulse, a fail flag is raised. The start/stop pair is sent in either case.

Outside a sequence, a small direct-control register lets software drive each line by hand and read back the sampled level of each line. All timing is counted in microseconds, using a tick derived from a clock-frequency parameter.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, both line drives are released (1), soft reset, clear-status, done and fail are 0, and direct-control readback bits 3:2 read 2'b11.
- R2: When idle, a write to the direct-control register sets the line drives: write bit 1 drives SDA and bit 0 drives SCL, with 1 meaning released. Readback bit 3 is the SDA drive, bit 2 the SCL drive, bit 1 the sampled SDA and bit 0 the sampled SCL.
- R3: A kick raises clear-status for exactly one cycle. The sequencer then checks the pending-transfer input at the end of each POLL_US interval. It enters soft reset at the first interval end where pending is low, or after POLL_MAX intervals, whichever comes first.
- R4: Soft reset stays asserted from the end of polling through the end of the stop condition. It is then released, and done follows HOLD_US later.
- R5: While soft reset is held and either sampled line is low, the sequencer drives SCL low for PULSE_US and then releases it for PULSE_US. SDA stays released during these pulses. No more than PULSE_MAX pulses are issued, and none once both lines read high.
- R6: Fail is set when the lines are still not both high after PULSE_MAX pulses. Fail is cleared by the next kick.
- R7: After pulsing ends, SDA is driven low with SCL released for HOLD_US (start). SDA is then released for HOLD_US (stop). SDA is never low while SCL is low under soft reset.
- R8: Done is a single-cycle pulse at the end of each sequence.
- R9: Direct-control writes and further kicks that arrive during a sequence have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kick_i | input | 1 | Start a recovery sequence (acted on only when idle) |
| xfer_pend_i | input | 1 | Controller reports a transfer still in progress |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| dc_wr_i | input | 1 | Direct-control register write strobe |
| dc_wdata_i | input | 2 | Direct-control write data: bit 1 SDA, bit 0 SCL |
| dc_rdata_o | output | 4 | Readback: SDA drive, SCL drive, SDA sample, SCL sample |
| scl_drv_o | output | 1 | SCL drive (1 releases the line) |
| sda_drv_o | output | 1 | SDA drive (1 releases the line) |
| soft_rst_o | output | 1 | Holds the transfer controller in reset |
| clr_stat_o | output | 1 | One-cycle request to clear sticky status bits |
| done_o | output | 1 | One-cycle pulse at sequence end |
| fail_o | output | 1 | Bus still held after the last clock pulse |

## Verification
The hardest condition to reach is a slave that holds SDA low for exactly PULSE_MAX pulses, or for one pulse more. That pair separates a clean finish from a failure by a single pulse. The bench models the slave as a counter of SCL rising edges under soft reset and releases SDA only after a chosen count. It sweeps that count across both sides of the limit, and also releases the pending-transfer input just after a chosen poll interval so that the poll-exit point moves.

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover #(
  parameter int CLK_MHZ   = 200,
  parameter int POLL_US   = 500,
  parameter int PULSE_US  = 100,
  parameter int HOLD_US   = 1000,
  parameter int POLL_MAX  = 10,
  parameter int PULSE_MAX = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kick_i,
  input  logic       xfer_pend_i,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       dc_wr_i,
  input  logic [1:0] dc_wdata_i,
  output logic [3:0] dc_rdata_o,
  output logic       scl_drv_o,
  output logic       sda_drv_o,
  output logic       soft_rst_o,
  output logic       clr_stat_o,
  output logic       done_o,
  output logic       fail_o
);
  localparam int PW  = $clog2(CLK_MHZ + 1);
  localparam int UW  = $clog2(POLL_US + PULSE_US + HOLD_US + 1);
  localparam int PCW = $clog2(POLL_MAX + 1);
  localparam int KW  = $clog2(PULSE_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_POLL, S_SRST, S_CHK, S_LOW, S_HIGH, S_START, S_STOP, S_SETTLE
  } st_t;

  st_t st, nxt;
  logic [PW-1:0]  pre;
  logic [UW-1:0]  us, lim;
  logic [PCW-1:0] pollc;
  logic [KW-1:0]  pcnt;
  logic [1:0]     dc_q;
  logic           tick, tdone, lines_ok, act;

  assign tick     = (pre == PW'(CLK_MHZ - 1));
  assign tdone    = tick && (us == lim - 1'b1);
  assign lines_ok = scl_in && sda_in;
  assign act      = (st != S_IDLE);

  always_comb begin
    case (st)
      S_POLL:                   lim = UW'(POLL_US);
      S_LOW, S_HIGH:            lim = UW'(PULSE_US);
      S_START, S_STOP, S_SETTLE: lim = UW'(HOLD_US);
      default:                  lim = UW'(1);
    endcase
  end

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:   if (kick_i) nxt = S_CLR;
      S_CLR:    nxt = S_POLL;
      S_POLL:   if (tdone && (!xfer_pend_i || pollc == PCW'(POLL_MAX - 1))) nxt = S_SRST;
      S_SRST:   nxt = S_CHK;
      S_CHK:    nxt = (lines_ok || pcnt == KW'(PULSE_MAX)) ? S_START : S_LOW;
      S_LOW:    if (tdone) nxt = S_HIGH;
      S_HIGH:   if (tdone) nxt = S_CHK;
      S_START:  if (tdone) nxt = S_STOP;
      S_STOP:   if (tdone) nxt = S_SETTLE;
      S_SETTLE: if (tdone) nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pre <= '0; us <= '0; pollc <= '0; pcnt <= '0;
      dc_q <= 2'b11; done_o <= 1'b0; fail_o <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt != st || tdone) begin
        pre <= '0; us <= '0;
      end else begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) us <= us + 1'b1;
      end
      if (st == S_CLR) begin
        pollc <= '0; pcnt <= '0; fail_o <= 1'b0;
      end
      if (st == S_POLL && tdone) pollc <= pollc + 1'b1;
      if (st == S_HIGH && tdone) pcnt <= pcnt + 1'b1;
      if (st == S_CHK && !lines_ok && pcnt == KW'(PULSE_MAX)) fail_o <= 1'b1;
      if (st == S_IDLE && dc_wr_i) dc_q <= dc_wdata_i;
      done_o <= (st == S_SETTLE) && tdone;
    end
  end

  assign soft_rst_o = (st == S_SRST) || (st == S_CHK) || (st == S_LOW) ||
                      (st == S_HIGH) || (st == S_START) || (st == S_STOP);
  assign clr_stat_o = (st == S_CLR);
  assign scl_drv_o  = act ? (st != S_LOW)   : dc_q[0];
  assign sda_drv_o  = act ? (st != S_START) : dc_q[1];
  assign dc_rdata_o = {sda_drv_o, scl_drv_o, sda_in, scl_in};

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_start_scl_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_o && !sda_drv_o) |-> scl_drv_o);
  p_pulse_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOW) |-> (pcnt < KW'(PULSE_MAX)));
  p_done_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !soft_rst_o);
  p_clr_before_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stat_o |=> (!clr_stat_o && !soft_rst_o));
  p_dc_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act && dc_wr_i) |=> $stable(dc_q));
endmodule

// File: tb/sim_i2c_bus_recover.sv
`timescale 1ns/1ps
module sim_i2c_bus_recover;
  localparam int CM = 4, PU = 5, LU = 3, HU = 6, PM = 10, KM = 10;

  logic clk = 1'b0, rst_n = 1'b0, kick = 1'b0, pend = 1'b0, dc_wr = 1'b0;
  logic [1:0] dc_wd = 2'b11;
  logic [3:0] dc_rd;
  logic scl_drv, sda_drv, soft_rst, clr_stat, done, fail, scl_in, sda_in;
  logic prev_scl = 1'b1, bus_clr = 1'b0;
  int K = 0, rises = 0, n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  assign scl_in = scl_drv;
  assign sda_in = sda_drv & (rises >= K);

  always @(posedge clk) begin
    prev_scl <= scl_drv;
    if (bus_clr) rises <= 0;
    else if (soft_rst && scl_drv && !prev_scl) rises <= rises + 1;
  end

  i2c_bus_recover #(.CLK_MHZ(CM), .POLL_US(PU), .PULSE_US(LU), .HOLD_US(HU),
                    .POLL_MAX(PM), .PULSE_MAX(KM)) u0 (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .xfer_pend_i(pend),
    .scl_in(scl_in), .sda_in(sda_in), .dc_wr_i(dc_wr), .dc_wdata_i(dc_wd),
    .dc_rdata_o(dc_rd), .scl_drv_o(scl_drv), .sda_drv_o(sda_drv),
    .soft_rst_o(soft_rst), .clr_stat_o(clr_stat), .done_o(done), .fail_o(fail));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pulses(input int k);
    return (k > KM) ? KM : k;
  endfunction
  function automatic int exp_pre(input int j);
    return 1 + CM * PU * (((j + 1) > PM) ? PM : (j + 1));
  endfunction

  task automatic dc_write(input logic [1:0] v);
    @(negedge clk); dc_wd = v; dc_wr = 1'b1;
    @(negedge clk); dc_wr = 1'b0;
  endtask

  task automatic run_seq(input int k, input int j);
    int pre_n = 0, clr_n = 0, sl = 0, pulses = 0, sdl = 0, setl = 0, viol = 0;
    int cyc = 0, done_w = 0;
    bit seen = 0, ps = 1;
    @(negedge clk); K = k; bus_clr = 1'b1; pend = 1'b1;
    @(negedge clk); bus_clr = 1'b0; kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    fork
      begin
        repeat (CM * PU * j + 7 - 1) @(negedge clk);
        pend = 1'b0;
      end
      begin
        while (!done && cyc < 4000) begin
          if (soft_rst) seen = 1;
          if (!seen && !soft_rst) pre_n++;
          if (clr_stat) clr_n++;
          if (!scl_drv) sl++;
          if (!scl_drv && ps) pulses++;
          ps = scl_drv;
          if (soft_rst && !sda_drv) sdl++;
          if (soft_rst && !sda_drv && !scl_drv) viol++;
          if (seen && !soft_rst) setl++;
          if (cyc == 30) begin dc_wd = 2'b00; dc_wr = 1'b1; kick = 1'b1; end
          if (cyc == 31) begin dc_wr = 1'b0; kick = 1'b0; end
          @(negedge clk); cyc++;
        end
        chk(soft_rst == 1'b0, "R4 released at done", soft_rst, 0);
        @(negedge clk);
        done_w = done;
      end
    join
    chk(clr_n == 1, "R3 clear-status width", clr_n, 1);
    chk(pre_n == exp_pre(j), "R3 poll cycles before soft reset", pre_n, exp_pre(j));
    chk(pulses == exp_pulses(k), "R5 clock pulses", pulses, exp_pulses(k));
    chk(sl == CM * LU * exp_pulses(k), "R5 SCL low cycles", sl, CM * LU * exp_pulses(k));
    chk(fail == (k > KM), "R6 fail flag", fail, (k > KM));
    chk(sdl == CM * HU, "R7 start hold cycles", sdl, CM * HU);
    chk(viol == 0, "R7 SDA low with SCL low", viol, 0);
    chk(setl == CM * HU, "R4 settle cycles", setl, CM * HU);
    chk(done_w == 0, "R8 done single cycle", done_w, 0);
    repeat (4) @(negedge clk);
    chk(!soft_rst && !clr_stat && !done, "R9 no restart from late kick",
        {soft_rst, clr_stat, done}, 0);
    chk(dc_rd[3:2] == 2'b11, "R9 direct-control write ignored", dc_rd[3:2], 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c2b));
    repeat (3) @(negedge clk);
    chk(scl_drv && sda_drv, "R1 lines released in reset", {scl_drv, sda_drv}, 3);
    chk(!soft_rst && !clr_stat && !done && !fail, "R1 control outputs idle",
        {soft_rst, clr_stat, done, fail}, 0);
    chk(dc_rd[3:2] == 2'b11, "R1 readback drive bits", dc_rd[3:2], 3);
    rst_n = 1'b1;
    dc_write(2'b01);
    @(negedge clk);
    chk(!sda_drv && scl_drv, "R2 manual drive", {sda_drv, scl_drv}, 1);
    chk(dc_rd == 4'b0101, "R2 readback", dc_rd, 5);
    K = 1; bus_clr = 1'b1; @(negedge clk); bus_clr = 1'b0;
    dc_write(2'b11);
    @(negedge clk);
    chk(dc_rd == 4'b1101, "R2 sampled SDA held low", dc_rd, 13);
    K = 0;
    run_seq(0, 0);
    run_seq(10, 11);
    run_seq(11, 2);
    run_seq(0, 9);
    run_seq(3, 5);
    for (int i = 0; i < 10; i++) run_seq($urandom_range(0, 12), $urandom_range(0, 11));
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule